// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Bank

This block watches a bank of already-synchronized input pins and turns selected signal transitions into interrupt events. Each pin carries a two-bit trigger selection that picks rising edges, falling edges, both, or nothing. A detected edge sets a sticky status bit for that pin. The bit stays set until software writes a one to it.

A per-pin mask keeps status bits from reaching the single bank interrupt line. Software sets mask bits through one register address and clears them through another, so no read-modify-write of the mask is ever needed. Status bits keep capturing edges while their pins are masked. Unmasking a pin that already holds a pending event therefore raises the interrupt at once.

The register port is a plain single-cycle bus. A write takes effect at the clock edge where `bus_en` and `bus_we` are high. Read data is combinational from the current state while `bus_en` is high and `bus_we` is low.

Top module: `gpio_edge_irq_bank`

## Requirements
- R1: After reset the status is all zeros, the mask is all ones, every pin's trigger selection is 2'b00 and `irq` is low.
- R2: With trigger 2'b01, a 0-to-1 change of a pin between two clock edges sets its status bit at the second edge. A falling change does not set it.
- R3: With trigger 2'b10, a 1-to-0 change of a pin sets its status bit. A rising change does not set it.
- R4: With trigger 2'b11, both rising and falling changes set the pin's status bit.
- R5: With trigger 2'b00, no change of that pin ever sets its status bit.
- R6: Address 0 reads the status vector (bit i = pin i). Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. Status bits are otherwise sticky.
- R7: An edge detected in the same cycle as a write-one-to-clear of the same bit leaves the bit set.
- R8: Writing ones to address 1 sets those mask bits, and writing ones to address 2 clears them. Zero bits leave the mask unchanged. Both addresses read the mask vector.
- R9: Status bits capture edges while their pins are masked.
- R10: `irq` is high exactly when some status bit is set whose mask bit is clear.
- R11: Pin i's control word is at address 32+i. The trigger selection occupies bits [4:3], and all other bits read as zero. Writes change only the addressed pin's trigger. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach is a pin edge that lands in exactly the same cycle as a write-one-to-clear of that pin's status bit. A random pin pattern alone rarely aligns with a clear write. The bench therefore drives this case directly. It first primes the pin low, then raises it in the very cycle that writes the clear, and then reads the status back. Beyond that, seeded random pin toggles are mixed with random register traffic, including writes to the mask-set and mask-clear addresses and control writes with junk in the unused bits. This exercises masked capture and the moment of unmasking against a bench model.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
   typedef enum logic [1:0] {
      TRIG_OFF  = 2'b00,
      TRIG_RISE = 2'b01,
      TRIG_FALL = 2'b10,
      TRIG_BOTH = 2'b11
   } trig_e;

   localparam int TRIG_LSB = 3;
endpackage

// File: rtl/gpirq_pin_cell.sv
module gpirq_pin_cell
   import gpirq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pin_in,
   input  logic  cfg_we,
   input  trig_e cfg_trig,
   output trig_e trig_q,
   output logic  hit
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         trig_q <= TRIG_OFF;
      end else begin
         prev_q <= pin_in;
         if (cfg_we) trig_q <= cfg_trig;
      end
   end

   always_comb begin
      unique case (trig_q)
         TRIG_RISE: hit = pin_in & ~prev_q;
         TRIG_FALL: hit = ~pin_in & prev_q;
         TRIG_BOTH: hit = pin_in ^ prev_q;
         default:   hit = 1'b0;
      endcase
   end

   // R2 R3 R4: an event is only ever reported when the pin level moved
   a_r2_hit_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (pin_in != prev_q));

   // R11: the trigger selection only changes on its own write strobe
   a_r11_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(trig_q));
endmodule

// File: rtl/gpirq_stat_mask.sv
module gpirq_stat_mask #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] hit,
   input  logic [NUM_PINS-1:0] stat_clr,
   input  logic [NUM_PINS-1:0] mask_set,
   input  logic [NUM_PINS-1:0] mask_clr,
   output logic [NUM_PINS-1:0] stat_q,
   output logic [NUM_PINS-1:0] mask_q,
   output logic                irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '1;
      end else begin
         stat_q <= (stat_q & ~stat_clr) | hit;
         mask_q <= (mask_q | mask_set) & ~mask_clr;
      end
   end

   assign irq = |(stat_q & ~mask_q);

   // R7 R9: every detected edge is recorded, whatever the clear or mask
   a_r7_hit_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((stat_q & $past(hit)) == $past(hit)));

   // R6: a set status bit drops only where a one was written to it
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(stat_q) & ~$past(stat_clr)) & ~stat_q) == '0));

   // R8: ones written to the set address land in the mask
   a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (|mask_set) |=> ((mask_q & $past(mask_set)) == $past(mask_set)));

   // R10: the interrupt only falls after a clear or a mask write
   a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past((|stat_clr) || (|mask_set)));
endmodule

// File: rtl/gpio_edge_irq_bank.sv
module gpio_edge_irq_bank
   import gpirq_pkg::*;
#(
   parameter int NUM_PINS  = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6,
   parameter int CTRL_BASE = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq
);
   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(2);

   if (NUM_PINS > DATA_W) begin : g_bad_width
      $error("NUM_PINS must not exceed DATA_W");
   end
   if (CTRL_BASE < 3 || CTRL_BASE + NUM_PINS > (1 << ADDR_W)) begin : g_bad_map
      $error("control words do not fit the address space");
   end
   if (DATA_W < TRIG_LSB + 2) begin : g_bad_data
      $error("DATA_W too narrow for the trigger field");
   end

   logic                wr;
   logic [ADDR_W-1:0]   ctrl_off;
   logic                ctrl_sel;
   logic [IDX_W-1:0]    ctrl_idx;
   logic [NUM_PINS-1:0] hit, stat_clr, mask_set, mask_clr, stat_q, mask_q;
   trig_e               trig_q [NUM_PINS];
   trig_e               wr_trig;

   assign wr       = bus_en & bus_we;
   assign ctrl_off = bus_addr - ADDR_W'(CTRL_BASE);
   assign ctrl_sel = (bus_addr >= ADDR_W'(CTRL_BASE)) && (ctrl_off < ADDR_W'(NUM_PINS));
   assign ctrl_idx = ctrl_off[IDX_W-1:0];
   assign wr_trig  = trig_e'(bus_wdata[TRIG_LSB +: 2]);

   assign stat_clr = (wr && bus_addr == A_STAT) ? bus_wdata[NUM_PINS-1:0] : '0;
   assign mask_set = (wr && bus_addr == A_MSET) ? bus_wdata[NUM_PINS-1:0] : '0;
   assign mask_clr = (wr && bus_addr == A_MCLR) ? bus_wdata[NUM_PINS-1:0] : '0;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpirq_pin_cell i_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_in   (pin_in[i]),
         .cfg_we   (wr && ctrl_sel && (ctrl_idx == IDX_W'(i))),
         .cfg_trig (wr_trig),
         .trig_q   (trig_q[i]),
         .hit      (hit[i])
      );
   end

   gpirq_stat_mask #(.NUM_PINS(NUM_PINS)) i_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .stat_clr (stat_clr),
      .mask_set (mask_set),
      .mask_clr (mask_clr),
      .stat_q   (stat_q),
      .mask_q   (mask_q),
      .irq      (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         if (bus_addr == A_STAT) begin
            bus_rdata[NUM_PINS-1:0] = stat_q;
         end else if (bus_addr == A_MSET || bus_addr == A_MCLR) begin
            bus_rdata[NUM_PINS-1:0] = mask_q;
         end else if (ctrl_sel) begin
            bus_rdata[TRIG_LSB +: 2] = trig_q[ctrl_idx];
         end
      end
   end
endmodule

// File: tb/test_gpio_edge_irq_bank.sv
module test_gpio_edge_irq_bank;
   localparam int N = 32;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0, errors = 0;
   int cyc = 0;
   bit done = 0;

   // bench model
   logic [N-1:0] m_stat, m_mask, m_prev;
   logic [1:0]   m_trig [N];

   always #2 clk = ~clk;

   gpio_edge_irq_bank i_gpio_edge_irq_bank (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   function automatic logic [31:0] model_read(logic [5:0] a);
      logic [31:0] r = '0;
      if (a == 0) r = m_stat;
      else if (a == 1 || a == 2) r = m_mask;
      else if (a >= 32) r[4:3] = m_trig[a-32];
      return r;
   endfunction

   function automatic logic [N-1:0] model_hits(logic [N-1:0] p);
      logic [N-1:0] h = '0;
      for (int i = 0; i < N; i++) begin
         case (m_trig[i])
            2'b01: h[i] = p[i] & ~m_prev[i];
            2'b10: h[i] = ~p[i] & m_prev[i];
            2'b11: h[i] = p[i] ^ m_prev[i];
            default: h[i] = 1'b0;
         endcase
      end
      return h;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: at negedge check irq, drive pins and bus, check read, advance model
   task automatic step(logic [N-1:0] p, logic en, logic we, logic [5:0] a,
                       logic [31:0] d, string tag);
      logic [N-1:0] h;
      @(negedge clk);
      check("R10 irq", {31'b0, irq}, {31'b0, |(m_stat & ~m_mask)});
      pin_in = p; bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
      #1;
      if (en && !we) check(tag, bus_rdata, model_read(a));
      h = model_hits(p);
      if (en && we) begin
         if (a == 0) m_stat = m_stat & ~d;
         else if (a == 1) m_mask = m_mask | d;
         else if (a == 2) m_mask = m_mask & ~d;
         else if (a >= 32) m_trig[a-32] = d[4:3];
      end
      m_stat = m_stat | h;
      m_prev = p;
      @(posedge clk);
      #0;
      bus_en = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, string tag);
      step(pin_in, 1'b1, 1'b0, a, 32'h0, tag);
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      step(pin_in, 1'b1, 1'b1, a, d, "wr");
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [N-1:0] p;
      int unsigned seed;
      seed = $urandom(32'h5eed);
      m_stat = '0; m_mask = '1; m_prev = '0;
      for (int i = 0; i < N; i++) m_trig[i] = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(6'd0, "R1 status");
      rd(6'd1, "R1 mask");
      rd(6'd37, "R1 trig");
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R11 junk bits dropped; neighbour untouched
      wr(6'd32, 32'hFFFF_FFFF);
      rd(6'd32, "R11 ctrl readback");
      rd(6'd33, "R11 neighbour");
      rd(6'd10, "R11 unused addr");
      wr(6'd32, 32'h0000_0008); // pin0 rising
      wr(6'd33, 32'h0000_0010); // pin1 falling
      wr(6'd34, 32'h0000_0018); // pin2 both
      wr(6'd35, 32'h0000_0000); // pin3 off
      // R9 edges while still masked
      step(32'h0000_000F, 0, 0, 0, 0, "");
      rd(6'd0, "R9 R2 R4 masked capture");
      step(32'h0000_0000, 0, 0, 0, 0, "");
      rd(6'd0, "R3 R4 falling capture");
      // R8 unmask pins 0..3
      wr(6'd2, 32'h0000_000F);
      rd(6'd1, "R8 mask clear");
      rd(6'd0, "R10 pending");
      // R6 zero writes ignored then clear
      wr(6'd0, 32'h0000_0000);
      rd(6'd0, "R6 zero write");
      wr(6'd0, 32'hFFFF_FFFF);
      rd(6'd0, "R6 cleared");
      // R5 pin3 toggling never sets
      step(32'h0000_0008, 0, 0, 0, 0, "");
      step(32'h0000_0000, 0, 0, 0, 0, "");
      rd(6'd0, "R5 off pin");
      // R7 edge coincident with clear
      step(32'h0000_0001, 1, 1, 6'd0, 32'h0000_0001, "");
      rd(6'd0, "R7 edge wins");
      wr(6'd1, 32'h0000_0001);
      rd(6'd1, "R8 mask set");

      // random phase
      for (int k = 0; k < 3000; k++) begin
         int unsigned op;
         p = pin_in ^ ($urandom & $urandom & $urandom);
         op = $urandom_range(0, 9);
         case (op)
            0: step(p, 1, 0, 6'd0, 0, "R2 R3 R4 R6 rand status");
            1: step(p, 1, 0, 6'd2, 0, "R8 rand mask");
            2: step(p, 1, 1, 6'd0, $urandom & $urandom, "");
            3: step(p, 1, 1, 6'd1, $urandom & $urandom, "");
            4: step(p, 1, 1, 6'd2, $urandom, "");
            5: step(p, 1, 1, 6'(32 + $urandom_range(0, 31)), $urandom, "");
            6: step(p, 1, 0, 6'(32 + $urandom_range(0, 31)), 0, "R11 rand ctrl");
            7: step(p, 1, 0, 6'($urandom_range(3, 31)), 0, "R11 rand unused");
            default: step(p, 0, 0, 0, 0, "");
         endcase
      end
      rd(6'd0, "R6 final status");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule